// File: doc/BRIEF.md
# Mode-Configurable Sum-of-Products Logic Core

This block is the logic core of a small programmable logic part. Eight macrocells each own eight product terms. Every product term is an AND of selected literals, and each literal is either the true or the complement form of one of sixteen array signals. Eight of those signals come from dedicated input pins. The other eight come from feedback slots, one per macrocell, and what feeds each slot depends on the mode. A single configuration load fixes three things: the global mode, the role and inversion of every macrocell, and the fuse pattern of the whole AND array.

The three modes distribute the product terms differently.
- Registered mode: input pin 0 acts as a clock and the last input pin acts as a shared active-low output enable for the flip-flops.
- Complex mode: every macrocell spends one term on its output enable, and the two end pins feed the array through the slots of the outermost macrocells.
- Simple mode: no terms are spent on enables, and feedback is shifted one place outward so that the two centre macrocells have no feedback path.

Each output is modelled as a data bit plus an enable bit. The pin level seen on the board comes back on a separate input. A synchronous reset stands in for power-up. A preload port can force any flip-flop to either level.

Top module: `sopcore_top`

## Requirements
- R1: Reset clears all eight flip-flops to 0, so a registered macrocell drives data 1. Reset also restores the blank configuration: simple mode, every role input, no inversion, and every fuse intact. In that state only the centre macrocells 3 and 4 are enabled, both driving 0.
- R2: The mode, roles, inversion bits and fuses are captured only on a clock edge with cfgLoad high. Changing them at any other time has no effect on the outputs.
- R3: Fuse bit ((m*8+p)*32 + 2*s + n) set to 1 connects literal s of product term p in macrocell m. Here n=0 selects the true form and n=1 the complement. A term with every fuse set evaluates to 0, and a term with every fuse cleared evaluates to 1. Array signals 0..7 are inPin[1..8], and signals 8..15 are feedback slots 0..7.
- R4: Mode codes are 0 (or 3) for simple, 1 for complex and 2 for registered. In simple mode a macrocell drives the OR of all eight terms XOR its inversion bit. Its enable is 1 unless its role is input, and macrocells 3 and 4 are always enabled.
- R5: In simple mode, slot 0 is inPin[9] and slot 7 is inPin[0]. Slots 1..3 carry the pin levels of macrocells 0..2, and slots 4..6 carry those of macrocells 5..7. The pins of macrocells 3 and 4 feed nothing.
- R6: In complex mode, term 0 is the output enable and the data is the OR of terms 1..7 XOR inversion. Slot 0 is inPin[9], slot 7 is inPin[0], and slots 1..6 carry the pin levels of macrocells 1..6.
- R7: In registered mode, flip-flops load on a system clock edge where inPin[0] is 1 after being 0 at the previous edge, and hold otherwise. A registered macrocell drives the inverse of its flip-flop, enabled while inPin[9] is 0.
- R8: In registered mode, a registered macrocell's flip-flop loads the OR of all eight terms XOR inversion, and its slot carries the flip-flop value. A combinatorial macrocell uses term 0 as enable, takes terms 1..7 as data, and feeds back its pin level.
- R9: While preloadEn is high, each flip-flop whose preloadMask bit is 1 loads its preloadVal bit on the next edge. Preload takes priority over a clock capture, and unmasked flip-flops keep their value.
- R10: Role codes are 0 combinatorial, 1 registered, and 2 or 3 input. An input-role macrocell has its enable at 0, except the centre macrocells in simple mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, standing in for power-up |
| cfgLoad | input | 1 | Configuration capture strobe |
| cfgMode | input | 2 | Global mode code |
| cfgRole | input | 16 | Two-bit role per macrocell, macrocell m at bits 2m+1:2m |
| cfgInv | input | 8 | Per-macrocell output inversion |
| cfgFuse | input | 2048 | AND-array fuse pattern |
| inPin | input | 10 | Dedicated input pins; bit 0 is the clock pin and bit 9 the enable pin in registered mode |
| padIn | input | 8 | Level observed on each macrocell pin |
| preloadEn | input | 1 | Flip-flop preload strobe |
| preloadMask | input | 8 | Selects the flip-flops to preload |
| preloadVal | input | 8 | Levels to preload |
| padOut | output | 8 | Data driven towards each macrocell pin |
| padOe | output | 8 | Drive enable for each macrocell pin |

## Verification
The bench loads one configuration per scenario and steers each expected value from a single literal.

Feedback routing is probed by raising one pin at a time. A design that left the slot mapping unshifted in simple mode, or gave the centre pins feedback, would light the wrong output. In complex mode, one macrocell has an always-true term 0 and empty data terms, which exposes an enable term wrongly added into the sum.

In registered mode, holding the clock pin high across several edges catches a level-sensitive capture. A chain of two flip-flops shows whether the feedback comes from the register or from the pin. Masked preloads show whether bits outside the mask are disturbed.

// File: rtl/sopcore_pkg.sv
package sopcore_pkg;

  typedef enum logic [1:0] {
    MODE_SIMPLE  = 2'd0,
    MODE_COMPLEX = 2'd1,
    MODE_REG     = 2'd2
  } modeE;

  localparam logic [1:0] ROLE_COMB = 2'd0;
  localparam logic [1:0] ROLE_REG  = 2'd1;

  typedef struct packed {
    logic capture;
    logic preload;
  } strobeT;

endpackage

// File: rtl/sopcore_ctrl.sv
module sopcore_ctrl
  import sopcore_pkg::*;
#(
  parameter int NUM_MC  = 8,
  parameter int NUM_PT  = 8,
  parameter int NUM_DIN = 8,
  localparam int NUM_SIG = NUM_DIN + NUM_MC,
  localparam int FUSE_W  = NUM_MC * NUM_PT * 2 * NUM_SIG
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgLoad,
  input  logic [1:0]          cfgMode,
  input  logic [2*NUM_MC-1:0] cfgRole,
  input  logic [NUM_MC-1:0]   cfgInv,
  input  logic [FUSE_W-1:0]   cfgFuse,
  input  logic                clkPin,
  input  logic                preloadEn,
  output modeE                modeQ,
  output logic [2*NUM_MC-1:0] roleQ,
  output logic [NUM_MC-1:0]   invQ,
  output logic [FUSE_W-1:0]   fuseQ,
  output strobeT              strobe
);

  logic clkPinPrev;
  modeE modeDec;

  always_comb begin
    case (cfgMode)
      2'd1:    modeDec = MODE_COMPLEX;
      2'd2:    modeDec = MODE_REG;
      default: modeDec = MODE_SIMPLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= MODE_SIMPLE;
      roleQ <= '1;
      invQ  <= '0;
      fuseQ <= '1;
    end else if (cfgLoad) begin
      modeQ <= modeDec;
      roleQ <= cfgRole;
      invQ  <= cfgInv;
      fuseQ <= cfgFuse;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clkPinPrev <= 1'b0;
    else     clkPinPrev <= clkPin;
  end

  always_comb begin
    strobe.capture = (modeQ == MODE_REG) && clkPin && !clkPinPrev;
    strobe.preload = preloadEn;
  end

  // R2: configuration holds without the load strobe
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cfgLoad |=> ($stable(modeQ) && $stable(roleQ) && $stable(invQ) && $stable(fuseQ)));

  // R7: one capture per rising level of the clock pin
  p_single_capture_r7: assert property (@(posedge clk) disable iff (rst)
    strobe.capture |=> !strobe.capture);

endmodule

// File: rtl/sopcore_datapath.sv
module sopcore_datapath
  import sopcore_pkg::*;
#(
  parameter int NUM_MC  = 8,
  parameter int NUM_PT  = 8,
  parameter int NUM_DIN = 8,
  localparam int NUM_SIG = NUM_DIN + NUM_MC,
  localparam int NUM_LIT = 2 * NUM_SIG,
  localparam int FUSE_W  = NUM_MC * NUM_PT * NUM_LIT,
  localparam int OE_PIN  = NUM_DIN + 1,
  localparam int MID_LO  = NUM_MC / 2 - 1,
  localparam int MID_HI  = NUM_MC / 2
) (
  input  logic                clk,
  input  logic                rst,
  input  modeE                mode,
  input  logic [2*NUM_MC-1:0] role,
  input  logic [NUM_MC-1:0]   inv,
  input  logic [FUSE_W-1:0]   fuse,
  input  strobeT              strobe,
  input  logic [NUM_DIN+1:0]  inPin,
  input  logic [NUM_MC-1:0]   padIn,
  input  logic [NUM_MC-1:0]   preloadMask,
  input  logic [NUM_MC-1:0]   preloadVal,
  output logic [NUM_MC-1:0]   padOut,
  output logic [NUM_MC-1:0]   padOe
);

  logic [NUM_MC-1:0]             regQ;
  logic [NUM_MC-1:0]             regD;
  logic [NUM_MC-1:0]             slot;
  logic [NUM_SIG-1:0]            sig;
  logic [NUM_LIT-1:0]            lits;
  logic [NUM_MC-1:0][NUM_PT-1:0] terms;

  // Feedback slot routing, chosen per mode
  for (genvar k = 0; k < NUM_MC; k++) begin : g_slot
    always_comb begin
      case (mode)
        MODE_REG:
          slot[k] = (role[2*k+:2] == ROLE_REG) ? regQ[k] : padIn[k];
        MODE_COMPLEX:
          if (k == 0)               slot[k] = inPin[OE_PIN];
          else if (k == NUM_MC - 1) slot[k] = inPin[0];
          else                      slot[k] = padIn[k];
        default:
          if (k == 0)               slot[k] = inPin[OE_PIN];
          else if (k == NUM_MC - 1) slot[k] = inPin[0];
          else if (k <= MID_LO)     slot[k] = padIn[k-1];
          else                      slot[k] = padIn[k+1];
      endcase
    end
  end

  assign sig = {slot, inPin[NUM_DIN:1]};

  for (genvar s = 0; s < NUM_SIG; s++) begin : g_lit
    assign lits[2*s]   = sig[s];
    assign lits[2*s+1] = ~sig[s];
  end

  // AND array: an intact fuse connects its literal
  for (genvar m = 0; m < NUM_MC; m++) begin : g_mc
    for (genvar p = 0; p < NUM_PT; p++) begin : g_pt
      assign terms[m][p] = &(lits | ~fuse[(m*NUM_PT+p)*NUM_LIT +: NUM_LIT]);
    end

    localparam bit IS_MID = (m == MID_LO) || (m == MID_HI);
    logic sumAll, sumTail, isInput;

    always_comb begin
      sumAll  = |terms[m];
      sumTail = |terms[m][NUM_PT-1:1];
      isInput = role[2*m+1];
      regD[m] = sumAll ^ inv[m];
      case (mode)
        MODE_REG: begin
          if (isInput) begin
            padOe[m]  = 1'b0;
            padOut[m] = sumTail ^ inv[m];
          end else if (role[2*m+:2] == ROLE_REG) begin
            padOe[m]  = !inPin[OE_PIN];
            padOut[m] = !regQ[m];
          end else begin
            padOe[m]  = terms[m][0];
            padOut[m] = sumTail ^ inv[m];
          end
        end
        MODE_COMPLEX: begin
          padOe[m]  = !isInput && terms[m][0];
          padOut[m] = sumTail ^ inv[m];
        end
        default: begin
          padOe[m]  = IS_MID || !isInput;
          padOut[m] = sumAll ^ inv[m];
        end
      endcase
    end

    // R10: input role leaves the pin undriven
    p_input_oe_off_r10: assert property (@(posedge clk) disable iff (rst)
      (isInput && !(IS_MID && mode != MODE_REG && mode != MODE_COMPLEX)) |-> !padOe[m]);

    // R7: registered pin follows the inverted flip-flop
    p_reg_pin_r7: assert property (@(posedge clk) disable iff (rst)
      (mode == MODE_REG && role[2*m+:2] == ROLE_REG && padOe[m]) |-> (padOut[m] != regQ[m]));
  end

  // Flip-flops: reset, then preload, then clock-pin capture
  always_ff @(posedge clk) begin
    if (rst)                 regQ <= '0;
    else if (strobe.preload) regQ <= (regQ & ~preloadMask) | (preloadVal & preloadMask);
    else if (strobe.capture) regQ <= regD;
  end

  // R1: flip-flops leave reset cleared
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (regQ == '0));

  // R7: flip-flops hold without capture or preload
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!strobe.capture && !strobe.preload) |=> $stable(regQ));

  // R9: masked bits take the preload value
  p_preload_r9: assert property (@(posedge clk) disable iff (rst)
    strobe.preload |=> ((regQ & $past(preloadMask)) == ($past(preloadVal) & $past(preloadMask))));

  // R4: centre macrocells always drive in simple mode
  p_mid_drive_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SIMPLE) |-> (padOe[MID_LO] && padOe[MID_HI]));

endmodule

// File: rtl/sopcore_top.sv
module sopcore_top
  import sopcore_pkg::*;
#(
  parameter int NUM_MC  = 8,
  parameter int NUM_PT  = 8,
  parameter int NUM_DIN = 8,
  localparam int NUM_SIG = NUM_DIN + NUM_MC,
  localparam int FUSE_W  = NUM_MC * NUM_PT * 2 * NUM_SIG
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgLoad,
  input  logic [1:0]          cfgMode,
  input  logic [2*NUM_MC-1:0] cfgRole,
  input  logic [NUM_MC-1:0]   cfgInv,
  input  logic [FUSE_W-1:0]   cfgFuse,
  input  logic [NUM_DIN+1:0]  inPin,
  input  logic [NUM_MC-1:0]   padIn,
  input  logic                preloadEn,
  input  logic [NUM_MC-1:0]   preloadMask,
  input  logic [NUM_MC-1:0]   preloadVal,
  output logic [NUM_MC-1:0]   padOut,
  output logic [NUM_MC-1:0]   padOe
);

  modeE                modeQ;
  logic [2*NUM_MC-1:0] roleQ;
  logic [NUM_MC-1:0]   invQ;
  logic [FUSE_W-1:0]   fuseQ;
  strobeT              strobe;

  sopcore_ctrl #(.NUM_MC(NUM_MC), .NUM_PT(NUM_PT), .NUM_DIN(NUM_DIN)) u_ctrl (
    .clk(clk), .rst(rst), .cfgLoad(cfgLoad), .cfgMode(cfgMode), .cfgRole(cfgRole),
    .cfgInv(cfgInv), .cfgFuse(cfgFuse), .clkPin(inPin[0]), .preloadEn(preloadEn),
    .modeQ(modeQ), .roleQ(roleQ), .invQ(invQ), .fuseQ(fuseQ), .strobe(strobe)
  );

  sopcore_datapath #(.NUM_MC(NUM_MC), .NUM_PT(NUM_PT), .NUM_DIN(NUM_DIN)) u_dp (
    .clk(clk), .rst(rst), .mode(modeQ), .role(roleQ), .inv(invQ), .fuse(fuseQ),
    .strobe(strobe), .inPin(inPin), .padIn(padIn), .preloadMask(preloadMask),
    .preloadVal(preloadVal), .padOut(padOut), .padOe(padOe)
  );

endmodule

// File: tb/sopcore_top_tb.sv
`timescale 1ns/1ps
module sopcore_top_tb;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfgLoad;
  logic [1:0]    cfgMode;
  logic [15:0]   cfgRole;
  logic [7:0]    cfgInv;
  logic [2047:0] cfgFuse;
  logic [9:0]    inPin;
  logic [7:0]    padIn;
  logic          preloadEn;
  logic [7:0]    preloadMask;
  logic [7:0]    preloadVal;
  logic [7:0]    padOut;
  logic [7:0]    padOe;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sopcore_top u_dut (
    .clk(clk), .rst(rst), .cfgLoad(cfgLoad), .cfgMode(cfgMode), .cfgRole(cfgRole),
    .cfgInv(cfgInv), .cfgFuse(cfgFuse), .inPin(inPin), .padIn(padIn),
    .preloadEn(preloadEn), .preloadMask(preloadMask), .preloadVal(preloadVal),
    .padOut(padOut), .padOe(padOe)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic blank();
    cfgFuse = '1;
    cfgRole = '0;
    cfgInv  = '0;
  endtask

  task automatic termLit(input int m, input int p, input int s, input int n);
    for (int l = 0; l < 32; l++) cfgFuse[(m*8+p)*32 + l] = 1'b0;
    cfgFuse[(m*8+p)*32 + 2*s + n] = 1'b1;
  endtask

  task automatic termOne(input int m, input int p);
    for (int l = 0; l < 32; l++) cfgFuse[(m*8+p)*32 + l] = 1'b0;
  endtask

  task automatic setRole(input int m, input logic [1:0] r);
    cfgRole[2*m +: 2] = r;
  endtask

  task automatic loadCfg(input logic [1:0] mode);
    cfgMode = mode;
    cfgLoad = 1'b1;
    tick(1);
    cfgLoad = 1'b0;
    #1;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inPin = '0; padIn = '0; preloadEn = 1'b0; cfgLoad = 1'b0;
    tick(2);
    rst = 1'b0;
    #1;
  endtask

  task automatic pulseClkPin();
    inPin[0] = 1'b1;
    tick(1);
    inPin[0] = 1'b0;
    tick(1);
    #1;
  endtask

  task automatic test_reset();
    doReset();
    chk("R1 blank oe", padOe, 8'h18);
    chk("R1 blank out", padOut, 8'h00);
    blank();
    for (int m = 0; m < 8; m++) setRole(m, 2'd1);
    loadCfg(2'd2);
    chk("R1 registered oe", padOe, 8'hFF);
    chk("R1 registered out high", padOut, 8'hFF);
  endtask

  task automatic test_simple();
    doReset();
    blank();
    termLit(0, 0, 0, 0);
    termLit(1, 0, 0, 1);
    cfgInv[2] = 1'b1;
    termOne(5, 0);
    setRole(6, 2'd2);
    setRole(3, 2'd2);
    loadCfg(2'd0);
    inPin[1] = 1'b1; #1;
    chk("R4/R3 simple out in1=1", padOut, 8'h25);
    chk("R10/R4 simple oe", padOe, 8'hBF);
    inPin[1] = 1'b0; #1;
    chk("R4/R3 simple out in1=0", padOut, 8'h26);
    cfgMode = 2'd3; loadCfg(2'd3);
    chk("R4 mode code 3 is simple", padOut, 8'h26);
  endtask

  task automatic test_simple_fb();
    doReset();
    blank();
    termLit(7, 0, 11, 0);
    termLit(6, 0, 8, 0);
    termLit(1, 0, 12, 0);
    loadCfg(2'd0);
    chk("R5 fb idle", padOut, 8'h00);
    padIn = 8'h04; #1;
    chk("R5 slot3 from mc2", padOut, 8'h80);
    padIn = 8'h00; inPin[9] = 1'b1; #1;
    chk("R5 slot0 from pin9", padOut, 8'h40);
    inPin[9] = 1'b0; padIn = 8'h20; #1;
    chk("R5 slot4 from mc5", padOut, 8'h02);
    padIn = 8'h18; #1;
    chk("R5 centre pins feed nothing", padOut, 8'h00);
    padIn = 8'h00;
  endtask

  task automatic test_complex();
    doReset();
    blank();
    termLit(1, 0, 0, 0);
    termLit(1, 1, 15, 0);
    termOne(0, 0);
    termLit(0, 1, 9, 0);
    termOne(2, 0);
    termOne(3, 0);
    setRole(3, 2'd2);
    loadCfg(2'd1);
    chk("R6 complex oe idle", padOe, 8'h05);
    chk("R6 enable term kept out of sum", padOut, 8'h00);
    inPin[1] = 1'b1; #1;
    chk("R6 oe term from in1", padOe, 8'h07);
    inPin[0] = 1'b1; #1;
    chk("R6 slot7 from pin0", padOut, 8'h02);
    padIn[1] = 1'b1; #1;
    chk("R6 slot1 from mc1 pin", padOut, 8'h03);
    inPin = '0; padIn = '0;
  endtask

  task automatic test_registered();
    doReset();
    blank();
    for (int m = 0; m < 8; m++) setRole(m, 2'd1);
    setRole(2, 2'd0);
    setRole(3, 2'd2);
    termLit(0, 0, 0, 0);
    termLit(1, 0, 8, 0);
    termOne(2, 0);
    termLit(2, 1, 1, 0);
    loadCfg(2'd2);
    chk("R10/R8 reg mode oe", padOe, 8'hF7);
    chk("R7 reg mode initial out", padOut, 8'hF3);
    inPin[1] = 1'b1; inPin[2] = 1'b1; #1;
    chk("R8 comb macrocell follows input", padOut, 8'hF7);
    tick(2); #1;
    chk("R7 no clock-pin edge holds", padOut, 8'hF7);
    inPin[0] = 1'b1;
    tick(1); #1;
    chk("R7 capture on clock-pin rise", padOut, 8'hF6);
    tick(3); #1;
    chk("R7 clock pin held high no capture", padOut, 8'hF6);
    inPin[0] = 1'b0;
    tick(1);
    pulseClkPin();
    chk("R8 feedback from flip-flop", padOut, 8'hF4);
    inPin[9] = 1'b1; #1;
    chk("R7/R8 enable pin only gates registered", padOe, 8'h04);
    inPin = '0;
  endtask

  task automatic test_preload();
    doReset();
    blank();
    for (int m = 0; m < 8; m++) setRole(m, 2'd1);
    loadCfg(2'd2);
    preloadEn = 1'b1; preloadMask = 8'h05; preloadVal = 8'h01;
    tick(1);
    preloadEn = 1'b0; #1;
    chk("R9 masked preload", padOut, 8'hFE);
    preloadEn = 1'b1; preloadMask = 8'h02; preloadVal = 8'hFF;
    tick(1);
    preloadEn = 1'b0; #1;
    chk("R9 unmasked bits kept", padOut, 8'hFC);
    pulseClkPin();
    chk("R9 capture after preload", padOut, 8'hFF);
  endtask

  task automatic test_cfg_hold();
    cfgMode = 2'd0;
    cfgRole = '1;
    cfgInv  = '1;
    cfgFuse = '0;
    tick(2); #1;
    chk("R2 cfg change without load oe", padOe, 8'hFF);
    chk("R2 cfg change without load out", padOut, 8'hFF);
  endtask

  initial begin
    rst = 1'b1; cfgLoad = 1'b0; cfgMode = '0; cfgRole = '0; cfgInv = '0; cfgFuse = '1;
    inPin = '0; padIn = '0; preloadEn = 1'b0; preloadMask = '0; preloadVal = '0;
    test_reset();
    test_simple();
    test_simple_fb();
    test_complex();
    test_registered();
    test_preload();
    test_cfg_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule